// File: doc/BRIEF.md
# Filter Configuration Port

This block is the processor-facing port of a filter chip. An external host reaches it as if it were a memory device. It uses a 9-bit address, a 16-bit data path and three active-low strobes: select, read and write. The address space has three regions. The first is a small bank of 16-bit control words. The second is a coefficient file of 128 words, grouped as four words per filter cell over 32 cells, with the cells split evenly between two filter paths. The third is a 256-word window onto an external snapshot memory, reached through a plain address, write-enable and data port.

The strobes arrive from outside the clock domain. A two-flop synchronizer handles them, and each write access commits exactly once. One control address also acts as a trigger: a write there raises a single-clock pulse that can be routed to a pin. The data pad itself sits outside the block. The block gives its input value, output value and output-enable. It turns the enable on only for a genuine read.

The host can tie the read strobe low permanently. Write-enable then acts as the transfer direction and select acts as the transfer strobe. The same decode serves both conventions. The filter datapath reads its coefficients one cell at a time through a four-word lookup port per path.

Top module: `filt_cfg_port`

## Requirements
- R1: Addresses 0 to 12 hold thirteen 16-bit control words. Each can be written and read back, and all of them appear on `ctrl_regs`, with word i at bits [16i+15:16i].
- R2: Address 128 + 4K + j holds coefficient word j (0..3) of cell K (0..31), and each word can be written and read back. Cells 0..15 feed path A and cells 16..31 feed path B. `pa_quad`/`pb_quad` show the four words of the cell picked by `pa_cell`/`pb_cell` (cell 16+c for path B), with word j at bits [16j+15:16j].
- R3: Addresses 13 to 127 are unmapped. A write there changes no control or coefficient word and raises no pulse, and a read there returns zero.
- R4: Addresses 256 to 511 map to the snapshot port with `snap_addr` = address − 256. A write raises `snap_we` for exactly one clock, carrying the written data on `snap_wdata`. A read returns `snap_rdata`.
- R5: A write takes effect once per access. The address and data are sampled on the third rising clock edge after select and write-enable both go low. Data changed later in the same access is ignored.
- R6: `bus_oe` is high only while `cs_n`=0, `rd_n`=0 and `wr_n`=1, and low for every other strobe combination.
- R7: A write to address 11 stores its data like any control word. It also makes `trig_pulse` high for exactly one clock, once per access however long the strobes stay low. Writes to any other address give no pulse.
- R8: With `rd_n` held at 0, `wr_n`=0 with `cs_n`=0 performs a write and `wr_n`=1 with `cs_n`=0 performs a read, with the same results as the separate-strobe convention.
- R9: Synchronous reset clears all control and coefficient words to zero, and `trig_pulse` and `snap_we` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Select strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 9 | Host address |
| bus_din | input | 16 | Data from the host pad |
| bus_dout | output | 16 | Read data toward the pad |
| bus_oe | output | 1 | Pad output enable |
| trig_pulse | output | 1 | One-clock trigger pulse |
| ctrl_regs | output | 208 | All control words, flattened |
| pa_cell | input | 4 | Path A cell select |
| pa_quad | output | 64 | Path A cell coefficients |
| pb_cell | input | 4 | Path B cell select (cell 16+pb_cell) |
| pb_quad | output | 64 | Path B cell coefficients |
| snap_addr | output | 8 | Snapshot memory address |
| snap_we | output | 1 | Snapshot write enable |
| snap_wdata | output | 16 | Snapshot write data |
| snap_rdata | input | 16 | Snapshot read data |

## Verification
The two functions that can coincide are a host write committing into a coefficient word and the datapath's lookup port reading the quad of that same cell. The bench holds `pa_cell` on the target cell through a whole write access and samples `pa_quad` every cycle. It passes only if the quad changes exactly once, from the old word to the new one, and leaves the other three words untouched. The same pattern is run against a long-held write to the trigger address, where the bench checks that the stored word and the single pulse both appear and the pulse is not repeated.

// File: rtl/filt_cfg_pkg.sv
package filt_cfg_pkg;

   // Address regions of the host port.
   typedef enum logic [1:0] {
      RGN_CTRL = 2'd0,
      RGN_NONE = 2'd1,
      RGN_COEF = 2'd2,
      RGN_SNAP = 2'd3
   } region_e;

   localparam int HOST_AW   = 9;
   localparam int HOST_DW   = 16;
   localparam int CTRL_CNT  = 13;
   localparam int TRIG_ADDR = 11;

endpackage

// File: rtl/filt_cfg_sync.sv
// Synchronizes an asynchronous active-high level and emits a one-clock
// pulse on its synchronized rising edge.
module filt_cfg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("filt_cfg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], async_in};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/filt_cfg_bank.sv
// Register bank with one write port, one indexed read port and a flat
// view of every word.
module filt_cfg_bank #(
   parameter int DW    = 16,
   parameter int DEPTH = 13,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                we,
   input  logic [IW-1:0]       widx,
   input  logic [DW-1:0]       wdata,
   input  logic [IW-1:0]       ridx,
   output logic [DW-1:0]       rdata,
   output logic [DEPTH*DW-1:0] flat
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("filt_cfg_bank: DEPTH must be positive");
      end
   endgenerate

   logic [DW-1:0] word_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst)                            word_q[g] <= '0;
         else if (we && widx == IW'(g))      word_q[g] <= wdata;
      end
      assign flat[g*DW +: DW] = word_q[g];
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (ridx == IW'(i)) rdata = word_q[i];
      end
   end
endmodule

// File: rtl/filt_cfg_port.sv
module filt_cfg_port
   import filt_cfg_pkg::*;
#(
   parameter int AW        = HOST_AW,
   parameter int DW        = HOST_DW,
   parameter int N_CTRL    = CTRL_CNT,
   parameter int OS_ADDR   = TRIG_ADDR,
   parameter int CELLS     = 16,
   parameter int QUAD      = 4,
   parameter int STAGES    = 2,
   localparam int PER_PATH = CELLS * QUAD,
   localparam int COEF_IW  = $clog2(PER_PATH),
   localparam int CELL_W   = $clog2(CELLS),
   localparam int SNAP_AW  = AW - 1,
   localparam int CTRL_IW  = $clog2(N_CTRL),
   localparam int QW       = QUAD * DW
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cs_n,
   input  logic                 rd_n,
   input  logic                 wr_n,
   input  logic [AW-1:0]        addr,
   input  logic [DW-1:0]        bus_din,
   output logic [DW-1:0]        bus_dout,
   output logic                 bus_oe,
   output logic                 trig_pulse,
   output logic [N_CTRL*DW-1:0] ctrl_regs,
   input  logic [CELL_W-1:0]    pa_cell,
   output logic [QW-1:0]        pa_quad,
   input  logic [CELL_W-1:0]    pb_cell,
   output logic [QW-1:0]        pb_quad,
   output logic [SNAP_AW-1:0]   snap_addr,
   output logic                 snap_we,
   output logic [DW-1:0]        snap_wdata,
   input  logic [DW-1:0]        snap_rdata
);
   // Elaboration-time consistency of the address map.
   generate
      if (2 * PER_PATH != (1 << (AW - 2))) begin : g_bad_coef_map
         $error("filt_cfg_port: two coefficient paths must fill a quarter of the address space");
      end
      if (N_CTRL > (1 << (AW - 2)) || N_CTRL < 2) begin : g_bad_ctrl
         $error("filt_cfg_port: N_CTRL out of range");
      end
      if (OS_ADDR >= N_CTRL) begin : g_bad_trig
         $error("filt_cfg_port: OS_ADDR must name a control word");
      end
   endgenerate

   // ---------------- strobe handling ----------------
   logic wr_act_raw;
   logic wr_go;

   assign wr_act_raw = ~cs_n & ~wr_n;

   filt_cfg_sync #(.STAGES(STAGES)) u_wsync (
      .clk      (clk),
      .rst      (rst),
      .async_in (wr_act_raw),
      .rise     (wr_go)
   );

   // ---------------- address decode ----------------
   region_e rgn;

   always_comb begin
      if (addr[AW-1])                          rgn = RGN_SNAP;
      else if (addr[AW-2])                     rgn = RGN_COEF;
      else if (addr < AW'(N_CTRL))             rgn = RGN_CTRL;
      else                                     rgn = RGN_NONE;
   end

   // ---------------- control bank ----------------
   logic [DW-1:0] ctrl_rd;
   logic          ctrl_we;

   assign ctrl_we = wr_go && (rgn == RGN_CTRL);

   filt_cfg_bank #(.DW(DW), .DEPTH(N_CTRL)) u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .we    (ctrl_we),
      .widx  (addr[CTRL_IW-1:0]),
      .wdata (bus_din),
      .ridx  (addr[CTRL_IW-1:0]),
      .rdata (ctrl_rd),
      .flat  (ctrl_regs)
   );

   // ---------------- coefficient banks, one per path ----------------
   logic [PER_PATH*DW-1:0] coef_flat [2];
   logic [DW-1:0]          coef_rd   [2];

   for (genvar p = 0; p < 2; p++) begin : g_path
      logic path_we;
      assign path_we = wr_go && (rgn == RGN_COEF) && (addr[COEF_IW] == 1'(p));

      filt_cfg_bank #(.DW(DW), .DEPTH(PER_PATH)) u_coef (
         .clk   (clk),
         .rst   (rst),
         .we    (path_we),
         .widx  (addr[COEF_IW-1:0]),
         .wdata (bus_din),
         .ridx  (addr[COEF_IW-1:0]),
         .rdata (coef_rd[p]),
         .flat  (coef_flat[p])
      );
   end

   assign pa_quad = coef_flat[0][pa_cell*QW +: QW];
   assign pb_quad = coef_flat[1][pb_cell*QW +: QW];

   // ---------------- snapshot window ----------------
   assign snap_addr  = addr[SNAP_AW-1:0];
   assign snap_wdata = bus_din;
   assign snap_we    = wr_go && (rgn == RGN_SNAP);

   // ---------------- trigger pulse ----------------
   logic trig_q;

   always_ff @(posedge clk) begin
      if (rst) trig_q <= 1'b0;
      else     trig_q <= wr_go && (rgn == RGN_CTRL) && (addr == AW'(OS_ADDR));
   end

   assign trig_pulse = trig_q;

   // ---------------- read path and pad enable ----------------
   always_comb begin
      unique case (rgn)
         RGN_CTRL: bus_dout = ctrl_rd;
         RGN_COEF: bus_dout = coef_rd[addr[COEF_IW]];
         RGN_SNAP: bus_dout = snap_rdata;
         default:  bus_dout = '0;
      endcase
   end

   assign bus_oe = ~cs_n & ~rd_n & wr_n;
endmodule

// File: rtl/filt_cfg_port_chk.sv
module filt_cfg_port_chk #(
   parameter int AW      = 9,
   parameter int DW      = 16,
   parameter int N_CTRL  = 13,
   parameter int OS_ADDR = 11,
   parameter int CW      = 1024
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 wr_go,
   input logic [AW-1:0]        wr_addr,
   input logic                 trig_pulse,
   input logic                 snap_we,
   input logic [N_CTRL*DW-1:0] ctrl_flat,
   input logic [CW-1:0]        coef_a,
   input logic [CW-1:0]        coef_b
);
   logic unmapped;
   assign unmapped = !wr_addr[AW-1] && !wr_addr[AW-2] && (wr_addr >= AW'(N_CTRL));

   // R7: trigger lasts one clock
   p_trig_width_r7: assert property (@(posedge clk) disable iff (rst)
      trig_pulse |=> !trig_pulse);

   // R7: trigger only follows a committed write to the trigger address
   p_trig_cause_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(trig_pulse) |-> ($past(wr_go) && $past(wr_addr) == AW'(OS_ADDR)));

   // R4: snapshot write strobe lasts one clock
   p_snap_once_r4: assert property (@(posedge clk) disable iff (rst)
      snap_we |=> !snap_we);

   // R5: no committed write, no change to control words
   p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !wr_go |=> $stable(ctrl_flat));

   // R3: writes to the unmapped hole leave all stored words alone
   p_hole_ignored_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_go && unmapped) |=> ($stable(ctrl_flat) && $stable(coef_a) && $stable(coef_b)));
endmodule

bind filt_cfg_port filt_cfg_port_chk #(
   .AW(AW), .DW(DW), .N_CTRL(N_CTRL), .OS_ADDR(OS_ADDR), .CW(PER_PATH*DW)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .wr_go      (wr_go),
   .wr_addr    (addr),
   .trig_pulse (trig_pulse),
   .snap_we    (snap_we),
   .ctrl_flat  (ctrl_regs),
   .coef_a     (coef_flat[0]),
   .coef_b     (coef_flat[1])
);

// File: tb/sim_filt_cfg_port.sv
`timescale 1ns/1ps
module sim_filt_cfg_port;
   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [8:0]    addr = '0;
   logic [15:0]   bus_din = '0;
   logic [15:0]   bus_dout;
   logic          bus_oe, trig_pulse, snap_we;
   logic [207:0]  ctrl_regs;
   logic [3:0]    pa_cell = '0, pb_cell = '0;
   logic [63:0]   pa_quad, pb_quad;
   logic [7:0]    snap_addr;
   logic [15:0]   snap_wdata, snap_rdata;

   int tests = 0, fails = 0;
   int trig_cnt = 0, snap_cnt = 0;
   logic [7:0]  snap_last_a;
   logic [15:0] snap_last_d;
   bit done = 0;

   always #2.5 clk = ~clk;

   // external snapshot memory model: data is a function of address
   assign snap_rdata = {~snap_addr, snap_addr};

   filt_cfg_port u0 (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
      .trig_pulse(trig_pulse), .ctrl_regs(ctrl_regs),
      .pa_cell(pa_cell), .pa_quad(pa_quad), .pb_cell(pb_cell), .pb_quad(pb_quad),
      .snap_addr(snap_addr), .snap_we(snap_we), .snap_wdata(snap_wdata),
      .snap_rdata(snap_rdata)
   );

   always @(negedge clk) begin
      if (!rst) begin
         if (trig_pulse) trig_cnt++;
         if (snap_we) begin
            snap_cnt++;
            snap_last_a = snap_addr;
            snap_last_d = snap_wdata;
         end
      end
   end

   function automatic logic [15:0] cval(int i);
      return 16'hC000 | 16'(i * 16'h0101);
   endfunction

   function automatic logic [15:0] gval(int n);
      return 16'(16'h4000 + n * 16'h0103);
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(int a, logic [15:0] d, int hold, bit alt);
      @(negedge clk);
      addr = 9'(a); bus_din = d; rd_n = alt ? 1'b0 : 1'b1;
      wr_n = 1'b0; cs_n = 1'b0;
      repeat (hold) @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_read(int a, bit alt, output logic [15:0] d, output logic oe);
      @(negedge clk);
      addr = 9'(a); wr_n = 1'b1; rd_n = 1'b0; cs_n = 1'b0;
      #1;
      d = bus_dout; oe = bus_oe;
      cs_n = 1'b1; rd_n = alt ? 1'b0 : 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic        oe;
      int          t0, s0;
      int          changes;
      logic [63:0] prevq;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R9: reset state
      check(ctrl_regs == '0, "R9 ctrl cleared", 64'(ctrl_regs[63:0]), 0);
      check(!trig_pulse && !snap_we && !bus_oe, "R9 idle outputs",
            {trig_pulse, snap_we, bus_oe}, 0);
      begin
         int bad = 0;
         for (int n = 0; n < 128; n++) begin
            do_read(128 + n, 0, d, oe);
            if (d != 0) bad++;
         end
         check(bad == 0, "R9 coefficients cleared", bad, 0);
      end

      // R1 / R7: sweep control words
      trig_cnt = 0;
      for (int i = 0; i < 13; i++) do_write(i, cval(i), 4, 0);
      for (int i = 0; i < 13; i++) begin
         do_read(i, 0, d, oe);
         check(d == cval(i) && oe, "R1 ctrl readback", d, cval(i));
         check(ctrl_regs[i*16 +: 16] == cval(i), "R1 ctrl_regs view",
               ctrl_regs[i*16 +: 16], cval(i));
      end
      check(trig_cnt == 1, "R7 single pulse from sweep", trig_cnt, 1);

      // R2: coefficient sweep
      for (int n = 0; n < 128; n++) do_write(128 + n, gval(n), 4, 0);
      begin
         int bad = 0;
         for (int n = 0; n < 128; n++) begin
            do_read(128 + n, 0, d, oe);
            if (d != gval(n)) begin
               bad++;
               check(0, "R2 coef readback", d, gval(n));
            end
         end
         check(bad == 0, "R2 coef readback sweep", bad, 0);
      end
      for (int c = 0; c < 16; c++) begin
         @(negedge clk);
         pa_cell = 4'(c); pb_cell = 4'(c);
         #1;
         for (int j = 0; j < 4; j++) begin
            check(pa_quad[j*16 +: 16] == gval(4*c + j), "R2 path A quad",
                  pa_quad[j*16 +: 16], gval(4*c + j));
            check(pb_quad[j*16 +: 16] == gval(64 + 4*c + j), "R2 path B quad",
                  pb_quad[j*16 +: 16], gval(64 + 4*c + j));
         end
      end

      // R3: unmapped hole
      t0 = trig_cnt;
      for (int a = 13; a < 128; a++) do_write(a, 16'hFFFF, 4, 0);
      begin
         int bad = 0;
         for (int a = 13; a < 128; a++) begin
            do_read(a, 0, d, oe);
            if (d != 0) bad++;
         end
         check(bad == 0, "R3 hole reads zero", bad, 0);
      end
      for (int i = 0; i < 13; i++)
         check(ctrl_regs[i*16 +: 16] == cval(i), "R3 ctrl untouched",
               ctrl_regs[i*16 +: 16], cval(i));
      do_read(128 + 5, 0, d, oe);
      check(d == gval(5), "R3 coef untouched", d, gval(5));
      check(trig_cnt == t0, "R3 no pulse", trig_cnt, t0);

      // R4: snapshot window
      for (int k = 0; k < 256; k += 37) begin
         s0 = snap_cnt;
         do_write(256 + k, 16'(16'h2000 + k), 6, 0);
         check(snap_cnt == s0 + 1, "R4 one snap_we", snap_cnt, s0 + 1);
         check(snap_last_a == 8'(k) && snap_last_d == 16'(16'h2000 + k),
               "R4 snap addr/data", {snap_last_a, snap_last_d}, {8'(k), 16'(16'h2000 + k)});
      end
      begin
         int bad = 0;
         for (int k = 0; k < 256; k++) begin
            do_read(256 + k, 0, d, oe);
            if (d != {~8'(k), 8'(k)}) bad++;
         end
         check(bad == 0, "R4 snapshot reads", bad, 0);
      end

      // R5: single commit, later data change ignored
      @(negedge clk);
      addr = 9'd3; bus_din = 16'h1234; wr_n = 1'b0; cs_n = 1'b0;
      repeat (5) @(negedge clk);
      bus_din = 16'hBEEF;
      repeat (10) @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      repeat (4) @(negedge clk);
      do_read(3, 0, d, oe);
      check(d == 16'h1234, "R5 late data ignored", d, 16'h1234);

      // R5: commit edge timing
      @(negedge clk);
      addr = 9'd4; bus_din = 16'h0F0F; wr_n = 1'b0; cs_n = 1'b0;
      @(negedge clk); @(negedge clk);
      check(ctrl_regs[4*16 +: 16] == cval(4), "R5 not before third edge",
            ctrl_regs[4*16 +: 16], cval(4));
      @(negedge clk);
      check(ctrl_regs[4*16 +: 16] == 16'h0F0F, "R5 on third edge",
            ctrl_regs[4*16 +: 16], 16'h0F0F);
      cs_n = 1'b1; wr_n = 1'b1;
      repeat (4) @(negedge clk);

      // R7: long write to trigger address, with concurrent stored value
      t0 = trig_cnt;
      do_write(11, 16'h5A5A, 25, 0);
      check(trig_cnt == t0 + 1, "R7 one pulse on long strobe", trig_cnt, t0 + 1);
      check(ctrl_regs[11*16 +: 16] == 16'h5A5A, "R7 trigger word stored",
            ctrl_regs[11*16 +: 16], 16'h5A5A);
      t0 = trig_cnt;
      do_write(10, 16'h0001, 4, 0);
      check(trig_cnt == t0, "R7 no pulse elsewhere", trig_cnt, t0);

      // R6: pad enable over all strobe combinations (address in the hole)
      for (int m = 0; m < 8; m++) begin
         @(negedge clk);
         addr = 9'd100;
         cs_n = m[2]; rd_n = m[1]; wr_n = m[0];
         #1;
         check(bus_oe == (!m[2] && !m[1] && m[0]), "R6 pad enable",
               bus_oe, (!m[2] && !m[1] && m[0]));
         @(negedge clk);
         cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
         repeat (4) @(negedge clk);
      end

      // R8: read strobe tied low
      @(negedge clk);
      rd_n = 1'b0;
      #1;
      check(!bus_oe, "R8 idle no drive", bus_oe, 0);
      do_write(6, 16'h7E57, 4, 1);
      do_write(128 + 70, 16'h0ACE, 4, 1);
      do_read(6, 1, d, oe);
      check(d == 16'h7E57 && oe, "R8 ctrl via direction mode", d, 16'h7E57);
      do_read(128 + 70, 1, d, oe);
      check(d == 16'h0ACE && oe, "R8 coef via direction mode", d, 16'h0ACE);
      t0 = trig_cnt;
      do_write(11, 16'h0011, 6, 1);
      check(trig_cnt == t0 + 1, "R8 trigger in direction mode", trig_cnt, t0 + 1);
      @(negedge clk);
      rd_n = 1'b1;

      // R2: lookup port and write in the same cycle window
      @(negedge clk);
      pa_cell = 4'd3;
      #1;
      prevq = pa_quad;
      changes = 0;
      addr = 9'(128 + 12 + 2); bus_din = 16'hD00D; wr_n = 1'b0; cs_n = 1'b0;
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if (pa_quad != prevq) changes++;
         prevq = pa_quad;
         if (c == 5) begin cs_n = 1'b1; wr_n = 1'b1; end
      end
      check(changes == 1, "R2 quad changes once", changes, 1);
      check(pa_quad[32 +: 16] == 16'hD00D, "R2 new word in quad", pa_quad[32 +: 16], 16'hD00D);
      check(pa_quad[0 +: 16] == gval(12) && pa_quad[16 +: 16] == gval(13) &&
            pa_quad[48 +: 16] == gval(15), "R2 neighbours kept",
            pa_quad, {gval(15), 16'hD00D, gval(13), gval(12)});

      // R9: reset clears again
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(ctrl_regs == '0 && pa_quad == '0, "R9 re-reset clears",
            64'(ctrl_regs[63:0]) | pa_quad, 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule